// File: doc/BRIEF.md
# Recursive Complete-Graph Network Next-Hop Router

This block computes the next hop for one router of a recursively built network-on-chip. The network has `RADIX_D` nodes in its basic module, which is a complete graph, and `LEVELS_T` levels of recursion. Each node carries an identifier of `LEVELS_T` base-`RADIX_D` digits. Digit 1, the least significant, sits in the lowest bits of the identifier. Given the identifier of the node that holds the packet and the identifier of its destination, the block returns one of three answers: an output port, an eject flag when the packet has arrived, or, when a port is chosen, whether that link is a substituting link or a flipping link, together with the link's label.

The route follows the recursive shortest-path construction. The block first finds the most significant digit position where the two identifiers differ; this is the level. The packet must cross the flipping link that bridges the two subnetworks one level below. The near end of that link keeps the upper digits and the current digit at the level position, and repeats the destination's level digit in every lower position. If the current node is that near end, the flipping link is taken. If it is not, the near end becomes the intermediate target and the search repeats. Each repetition lowers the level by at least one, so the search is unrolled into `LEVELS_T` combinational stages, and the answer is registered one clock after the request.

Port numbering at a node whose lowest digit is `a1`: port `k` with `k != a1` is the substituting link to the neighbour whose lowest digit is `k`. Port `a1` is the node's single flipping link, or its open link, because a node has no substituting link to itself.

Top module: `wk_next_hop_router`

## Requirements
- R1: When a request has equal current and destination identifiers, the response has eject = 1, flip = 0, port = 0 and label = 0.
- R2: When the identifiers differ only in digit 1, the response has flip = 0, label = 0 and port equal to the destination's digit 1.
- R3: When the current node is the near end of the bridge at the differing level i (digits below i all equal to the destination's digit i, digit i equal to its own), the response has flip = 1, port equal to the current digit 1 and label = i-1.
- R4: Otherwise the response is the next hop toward that near end, found by the same rules applied again; for example from 000 to 333 (radix 4, three levels) the answer is substituting port 3.
- R5: A substituting answer never uses the port equal to the current digit 1. A flipping answer always uses that port, and its label equals the number of equal low digits at the current node, which is never all of them (the open link is never chosen).
- R6: Following the answers hop by hop from any source reaches any destination in at most 2^LEVELS_T - 1 hops, and each hop crosses a link that exists.
- R7: rsp_valid is high in exactly the cycle after a cycle with req_valid high. The response fields change only in that cycle and hold their values otherwise.
- R8: A synchronous active-high reset clears rsp_valid, rsp_eject, rsp_flip, rsp_port and rsp_label to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for cur_id and dst_id |
| cur_id | input | LEVELS_T*DW | Identifier of the node holding the packet, digit 1 in the low DW bits |
| dst_id | input | LEVELS_T*DW | Destination identifier, same layout |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_eject | output | 1 | Packet has arrived; deliver locally |
| rsp_flip | output | 1 | 1 for a flipping link, 0 for a substituting link |
| rsp_port | output | DW | Output port number (0 to RADIX_D-1) |
| rsp_label | output | LW | Label of the chosen link (0 for substituting) |

DW is the bit width of one digit, ceil(log2(RADIX_D)). LW is ceil(log2(LEVELS_T+1)).

## Verification
Every response is due exactly one clock edge after the request. The bench drives a request on a falling edge and reads the response on the next falling edge, which falls after the single registering edge. It then checks in the following idle cycle that rsp_valid drops and the fields hold. Hand-worked cases cover eject, the lowest-level substitution, taking the bridge and recursing toward it. An exhaustive walk over all source and destination pairs then moves a model node along each answered link, using an adjacency rule computed in the bench. The walk checks that each link exists, that its label is correct, and that the destination is reached within the diameter.

// File: rtl/wk_route_pkg.sv
package wk_route_pkg;
  typedef enum logic [1:0] {
    HOP_PENDING = 2'd0,
    HOP_EJECT   = 2'd1,
    HOP_SUBST   = 2'd2,
    HOP_FLIP    = 2'd3
  } hop_kind_e;
endpackage

// File: rtl/wk_level_find.sv
module wk_level_find #(
  parameter int LEVELS_T = 3,
  parameter int DW       = 2,
  parameter int LW       = 2
) (
  input  logic [LEVELS_T*DW-1:0] id_a,
  input  logic [LEVELS_T*DW-1:0] id_b,
  output logic [LW-1:0]          level
);
  // Highest digit position (1-based) where the identifiers differ, 0 if equal.
  always_comb begin
    level = '0;
    for (int k = 1; k <= LEVELS_T; k++) begin
      if (id_a[(k-1)*DW +: DW] != id_b[(k-1)*DW +: DW]) level = LW'(k);
    end
  end
endmodule

// File: rtl/wk_bridge_gen.sv
module wk_bridge_gen #(
  parameter int LEVELS_T = 3,
  parameter int DW       = 2,
  parameter int LW       = 2
) (
  input  logic [LEVELS_T*DW-1:0] cur_id,
  input  logic [LEVELS_T*DW-1:0] tgt_id,
  input  logic [LW-1:0]          level,
  output logic [LEVELS_T*DW-1:0] near_id
);
  logic [DW-1:0] tgt_digit;

  // Destination digit at the differing level.
  always_comb begin
    tgt_digit = '0;
    for (int k = 1; k <= LEVELS_T; k++) begin
      if (LW'(k) == level) tgt_digit = tgt_id[(k-1)*DW +: DW];
    end
  end

  // Near end of the bridge: upper and level digits from the current node,
  // every lower digit replaced by the destination's level digit.
  always_comb begin
    for (int k = 1; k <= LEVELS_T; k++) begin
      if (LW'(k) < level) near_id[(k-1)*DW +: DW] = tgt_digit;
      else                near_id[(k-1)*DW +: DW] = cur_id[(k-1)*DW +: DW];
    end
  end
endmodule

// File: rtl/wk_hop_stage.sv
module wk_hop_stage
  import wk_route_pkg::*;
#(
  parameter int LEVELS_T = 3,
  parameter int DW       = 2,
  parameter int LW       = 2
) (
  input  logic [LEVELS_T*DW-1:0] cur_id,
  input  logic [LEVELS_T*DW-1:0] tgt_in,
  input  hop_kind_e              kind_in,
  input  logic [DW-1:0]          port_in,
  input  logic [LW-1:0]          label_in,
  output logic [LEVELS_T*DW-1:0] tgt_out,
  output hop_kind_e              kind_out,
  output logic [DW-1:0]          port_out,
  output logic [LW-1:0]          label_out
);
  logic [LW-1:0]          level;
  logic [LEVELS_T*DW-1:0] near_id;

  wk_level_find #(.LEVELS_T(LEVELS_T), .DW(DW), .LW(LW)) level_i (
    .id_a  (cur_id),
    .id_b  (tgt_in),
    .level (level)
  );

  wk_bridge_gen #(.LEVELS_T(LEVELS_T), .DW(DW), .LW(LW)) bridge_i (
    .cur_id  (cur_id),
    .tgt_id  (tgt_in),
    .level   (level),
    .near_id (near_id)
  );

  always_comb begin
    tgt_out   = tgt_in;
    kind_out  = kind_in;
    port_out  = port_in;
    label_out = label_in;
    if (kind_in == HOP_PENDING) begin
      if (level == '0) begin
        kind_out  = HOP_EJECT;
        port_out  = '0;
        label_out = '0;
      end else if (level == LW'(1)) begin
        kind_out  = HOP_SUBST;
        port_out  = tgt_in[DW-1:0];
        label_out = '0;
      end else if (near_id == cur_id) begin
        kind_out  = HOP_FLIP;
        port_out  = cur_id[DW-1:0];
        label_out = level - LW'(1);
      end else begin
        tgt_out = near_id;
      end
    end
  end
endmodule

// File: rtl/wk_next_hop_router.sv
module wk_next_hop_router
  import wk_route_pkg::*;
#(
  parameter int RADIX_D  = 4,
  parameter int LEVELS_T = 3,
  localparam int DW = (RADIX_D > 2) ? $clog2(RADIX_D) : 1,
  localparam int AW = LEVELS_T * DW,
  localparam int LW = (LEVELS_T > 0) ? $clog2(LEVELS_T + 1) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] cur_id,
  input  logic [AW-1:0] dst_id,
  output logic          rsp_valid,
  output logic          rsp_eject,
  output logic          rsp_flip,
  output logic [DW-1:0] rsp_port,
  output logic [LW-1:0] rsp_label
);
  // Chain of unrolled search stages; each one lowers the level by at least one.
  logic [AW-1:0] tgt_chain   [LEVELS_T+1];
  hop_kind_e     kind_chain  [LEVELS_T+1];
  logic [DW-1:0] port_chain  [LEVELS_T+1];
  logic [LW-1:0] label_chain [LEVELS_T+1];

  assign tgt_chain[0]   = dst_id;
  assign kind_chain[0]  = HOP_PENDING;
  assign port_chain[0]  = '0;
  assign label_chain[0] = '0;

  for (genvar s = 0; s < LEVELS_T; s++) begin : g_stage
    wk_hop_stage #(.LEVELS_T(LEVELS_T), .DW(DW), .LW(LW)) stage_i (
      .cur_id    (cur_id),
      .tgt_in    (tgt_chain[s]),
      .kind_in   (kind_chain[s]),
      .port_in   (port_chain[s]),
      .label_in  (label_chain[s]),
      .tgt_out   (tgt_chain[s+1]),
      .kind_out  (kind_chain[s+1]),
      .port_out  (port_chain[s+1]),
      .label_out (label_chain[s+1])
    );
  end

  hop_kind_e final_kind;
  assign final_kind = kind_chain[LEVELS_T];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_eject <= 1'b0;
      rsp_flip  <= 1'b0;
      rsp_port  <= '0;
      rsp_label <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_eject <= (final_kind == HOP_EJECT);
        rsp_flip  <= (final_kind == HOP_FLIP);
        rsp_port  <= port_chain[LEVELS_T];
        rsp_label <= label_chain[LEVELS_T];
      end
    end
  end

  // R1: eject exactly when the identifiers of the request matched.
  assert_eject_equal_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_eject == ($past(cur_id) == $past(dst_id))));

  // R2: a substituting or eject answer carries label 0.
  assert_subst_label_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_flip || rsp_label == '0));

  // R3: a flipping answer leaves through the port of the node's own low digit.
  assert_flip_port_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_flip || rsp_port == $past(cur_id[DW-1:0])));

  // R5: a substituting answer never points back at the node itself.
  assert_subst_port_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_flip || rsp_eject || rsp_port != $past(cur_id[DW-1:0])));

  // R7: response strobe follows the request strobe by one cycle.
  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_port) && $stable(rsp_label) && $stable(rsp_flip)));

  // R1/R3: eject and flip are never reported together.
  assert_kind_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(rsp_eject && rsp_flip));
endmodule

// File: tb/wk_next_hop_router_tb.sv
module wk_next_hop_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD = 4;
  localparam int LT = 3;
  localparam int DWB = 2;
  localparam int AWB = LT * DWB;
  localparam int LWB = 2;
  localparam int DIAM = (1 << LT) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [AWB-1:0] cur_id = '0;
  logic [AWB-1:0] dst_id = '0;
  logic           rsp_valid, rsp_eject, rsp_flip;
  logic [DWB-1:0] rsp_port;
  logic [LWB-1:0] rsp_label;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wk_next_hop_router #(.RADIX_D(RD), .LEVELS_T(LT)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cur_id(cur_id), .dst_id(dst_id),
    .rsp_valid(rsp_valid), .rsp_eject(rsp_eject), .rsp_flip(rsp_flip),
    .rsp_port(rsp_port), .rsp_label(rsp_label)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [AWB-1:0] mk(input int a3, input int a2, input int a1);
    return {2'(a3), 2'(a2), 2'(a1)};
  endfunction

  function automatic int dig(input logic [AWB-1:0] id, input int k);
    return int'(id[(k-1)*DWB +: DWB]);
  endfunction

  // One request: drive on a falling edge, read after the next rising edge.
  task automatic query(input logic [AWB-1:0] c, input logic [AWB-1:0] d);
    req_valid = 1'b1;
    cur_id = c;
    dst_id = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_hop(input string tag, input logic [AWB-1:0] c, input logic [AWB-1:0] d,
                            input int ej, input int fl, input int pt, input int lb);
    query(c, d);
    check({tag, " valid"}, int'(rsp_valid), 1);
    check({tag, " eject"}, int'(rsp_eject), ej);
    check({tag, " flip"}, int'(rsp_flip), fl);
    check({tag, " port"}, int'(rsp_port), pt);
    check({tag, " label"}, int'(rsp_label), lb);
  endtask

  task automatic test_reset;
    check("R8 valid in reset", int'(rsp_valid), 0);
    check("R8 eject in reset", int'(rsp_eject), 0);
    check("R8 flip in reset", int'(rsp_flip), 0);
    check("R8 port in reset", int'(rsp_port), 0);
    check("R8 label in reset", int'(rsp_label), 0);
  endtask

  task automatic test_eject;
    expect_hop("R1 000", mk(0,0,0), mk(0,0,0), 1, 0, 0, 0);
    expect_hop("R1 213", mk(2,1,3), mk(2,1,3), 1, 0, 0, 0);
    expect_hop("R1 333", mk(3,3,3), mk(3,3,3), 1, 0, 0, 0);
  endtask

  task automatic test_subst;
    expect_hop("R2 012->010", mk(0,1,2), mk(0,1,0), 0, 0, 0, 0);
    expect_hop("R2 333->331", mk(3,3,3), mk(3,3,1), 0, 0, 1, 0);
    expect_hop("R2 200->203", mk(2,0,0), mk(2,0,3), 0, 0, 3, 0);
  endtask

  task automatic test_bridge;
    expect_hop("R3 033->300", mk(0,3,3), mk(3,0,0), 0, 1, 3, 2);
    expect_hop("R3 012->021", mk(0,1,2), mk(0,2,1), 0, 1, 2, 1);
    expect_hop("R3 122->211", mk(1,2,2), mk(2,1,1), 0, 1, 2, 2);
  endtask

  task automatic test_recurse;
    expect_hop("R4 000->333", mk(0,0,0), mk(3,3,3), 0, 0, 3, 0);
    expect_hop("R4 011->020", mk(0,1,1), mk(0,2,0), 0, 0, 2, 0);
    expect_hop("R4 030->300", mk(0,3,0), mk(3,0,0), 0, 0, 3, 0);
    expect_hop("R4 003->300", mk(0,0,3), mk(3,0,0), 0, 1, 3, 1);
  endtask

  task automatic test_timing;
    query(mk(1,0,2), mk(1,0,1));
    check("R7 valid after request", int'(rsp_valid), 1);
    check("R7 port after request", int'(rsp_port), 1);
    cur_id = mk(3,2,1);
    dst_id = mk(0,0,0);
    @(negedge clk);
    check("R7 valid idle", int'(rsp_valid), 0);
    check("R7 port held", int'(rsp_port), 1);
    check("R7 flip held", int'(rsp_flip), 0);
  endtask

  // Exhaustive walk with an adjacency model written from the link definitions.
  task automatic test_walk;
    for (int s = 0; s < (1 << AWB); s++) begin
      for (int d = 0; d < (1 << AWB); d++) begin
        logic [AWB-1:0] node;
        int hops;
        bit arrived;
        node = AWB'(s);
        hops = 0;
        arrived = 1'b0;
        while (!arrived && hops <= DIAM) begin
          query(node, AWB'(d));
          if (rsp_eject) begin
            arrived = 1'b1;
          end else if (!rsp_flip) begin
            if (int'(rsp_port) == dig(node, 1))
              check("R5 substituting port differs from own digit", int'(rsp_port), -1);
            node[DWB-1:0] = rsp_port;
            hops++;
          end else begin
            int run;
            int low;
            int up;
            run = 1;
            while (run < LT && dig(node, run + 1) == dig(node, 1)) run++;
            if (run == LT) begin
              check("R5 open link chosen", 1, 0);
              hops = DIAM + 1;
            end else begin
              if (int'(rsp_port) != dig(node, 1) || int'(rsp_label) != run) begin
                check("R5 flip port", int'(rsp_port), dig(node, 1));
                check("R5 flip label", int'(rsp_label), run);
              end
              low = dig(node, 1);
              up = dig(node, run + 1);
              node[run*DWB +: DWB] = DWB'(low);
              for (int k = 1; k <= run; k++) node[(k-1)*DWB +: DWB] = DWB'(up);
              hops++;
            end
          end
        end
        check("R6 destination reached", int'(arrived), 1);
        if (arrived) check("R6 reached node", int'(node), d);
        if (hops > DIAM) check("R6 hops within diameter", hops, DIAM);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst = 1'b0;
    @(negedge clk);
    test_eject;
    test_subst;
    test_bridge;
    test_recurse;
    test_timing;
    test_walk;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule